// File: doc/BRIEF.md
# Two-Wire Serial Control-Register Slave

This block is a slave on a two-wire serial bus of the I2C kind. It samples the bus clock and data lines with the system clock and filters short glitches from both. It tracks the START and STOP conditions and answers only its own fixed 7-bit device address. Behind the bus sits a pair of 8-bit control registers. Their bits drive the clock-output select, per-output disable and power-down controls of a clock-generator core.

The master addresses a register with one byte, and the block keeps a 4-bit register pointer. The high nibble of a register address is always taken as 1111. Only the addresses 0xFE and 0xFF hold storage. The pointer steps after each data byte, and a step from 0xFF returns to 0xFE. Current-address, random and sequential reads and multi-byte writes all use this pointer. The data line is driven only as an active-low open-drain enable.

Top module: `twi_regslave`

## Requirements
- R1: After reset, register 0xFF reads 0x0C and register 0xFE reads 0x00. This gives pwr_down=0, clk34_sel=3, clk2_alt=0, clk1_alt=0 and out_off=0. The data line is released, and the register pointer addresses 0xFE.
- R2: The block acknowledges a first byte only when its upper seven bits equal 1010110. Bit 0 of that byte is the transfer direction: 1 means read and 0 means write. Any other first byte gets no acknowledge.
- R3: A write holds the device byte (direction 0), then a register-address byte, then data bytes. Each byte is MSB first, and the block acknowledges each one. Register 0xFF keeps bits 7 and 3:0 and reads 0 in bits 6:4. Register 0xFE keeps bits 7:3 and reads 0 in bits 2:0.
- R4: Each further data byte in a write goes to the next pointer value. The pointer increments within the high nibble 1111, and 0xFF is followed by 0xFE.
- R5: A read that sends no register address returns the register one past the last accessed address, using the same wrap.
- R6: A register-address write, then a repeated START and a device byte with direction 1, returns the addressed register.
- R7: In a read, the block sends the next register after each master acknowledge. After a master NACK it leaves the data line released.
- R8: Register addresses use only their low nibble. Nibbles other than E and F are acknowledged, but writes to them change nothing and reads from them return 0x00.
- R9: A START or STOP in the middle of a byte discards that byte. After a STOP the block waits idle. After a START it expects a new device byte.
- R10: A level on either bus line that lasts fewer than GLITCH_CYC system clocks is ignored.
- R11: Register 0xFF bit 7 drives pwr_down, bits 3:2 drive clk34_sel, bit 1 drives clk2_alt and bit 0 drives clk1_alt. Register 0xFE bits 7:3 drive out_off[4:0].
- R12: The block changes its data-line drive only while the filtered bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pwr_down | output | 1 | Power-down control |
| clk34_sel | output | 2 | Frequency select for outputs 3 and 4 |
| clk2_alt | output | 1 | Frequency select for output 2 |
| clk1_alt | output | 1 | Frequency select for output 1 |
| out_off | output | 5 | Per-output disables: 4 clk4, 3 clk3, 2 clk2, 1 clk1, 0 reference |

## Verification
Four properties hold on every cycle:
- the data-line drive changes only while the filtered clock is low;
- a filtered line takes a new value only after at least two synchronised samples agree;
- the control outputs change only after a data-byte phase;
- the data line stays released during the master acknowledge slot.

The checker also confirms that every START sends the block to the address phase. Address matching, pointer stepping and wrap, masked register bits, abort handling and glitch immunity show only in the bench's bus transactions. There the bench compares acknowledges, read data and decoded outputs against its own register model.

// File: rtl/twi_regslave.sv
module twi_regslave #(
  parameter logic [6:0] DEV_ADDR   = 7'b1010110,
  parameter int         GLITCH_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       pwr_down,
  output logic [1:0] clk34_sel,
  output logic       clk2_alt,
  output logic       clk1_alt,
  output logic [4:0] out_off
);

  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [7:0] CTL_MASK = 8'h8F;
  localparam logic [7:0] DIS_MASK = 8'hF8;
  localparam logic [7:0] CTL_RST  = 8'h0C;

  localparam logic [3:0] S_IDLE = 4'd0, S_DEV = 4'd1, S_DACK = 4'd2, S_REG = 4'd3,
                         S_AACK = 4'd4, S_WDATA = 4'd5, S_WACK = 4'd6, S_RD = 4'd7,
                         S_MACK = 4'd8;

  logic [1:0]    raw, s1, s2, filt, prev;
  logic [CW-1:0] gcnt [2];

  assign raw = {sda_i, scl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 2'b11;
      s2   <= 2'b11;
      filt <= 2'b11;
      prev <= 2'b11;
      for (int i = 0; i < 2; i++) gcnt[i] <= '0;
    end else begin
      s1   <= raw;
      s2   <= s1;
      prev <= filt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == filt[i]) gcnt[i] <= '0;
        else if (gcnt[i] == CW'(GLITCH_CYC - 1)) begin
          filt[i] <= s2[i];
          gcnt[i] <= '0;
        end else gcnt[i] <= gcnt[i] + 1'b1;
      end
    end
  end

  logic scl_f, sda_f, scl_rise, scl_fall, start, stop;
  assign scl_f    = filt[0];
  assign sda_f    = filt[1];
  assign scl_rise = scl_f & ~prev[0];
  assign scl_fall = ~scl_f & prev[0];
  assign start    = scl_f & prev[0] & prev[1] & ~sda_f;
  assign stop     = scl_f & prev[0] & ~prev[1] & sda_f;

  logic [3:0] st, cnt, ptr, ptr_nxt;
  logic [7:0] shr, ctl_q, dis_q, rd_ptr;
  logic       rw, mack;

  assign ptr_nxt = (ptr == 4'hF) ? 4'hE : ptr + 4'd1;
  assign rd_ptr  = (ptr == 4'hF) ? ctl_q : (ptr == 4'hE) ? dis_q : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ptr    <= 4'hE;
      shr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      ctl_q  <= CTL_RST;
      dis_q  <= 8'h00;
    end else if (stop) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start) begin
      st     <= S_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_REG, S_WDATA: begin
          if (scl_rise) begin
            shr <= {shr[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == S_DEV) begin
              if (shr[7:1] == DEV_ADDR) begin
                rw     <= shr[0];
                sda_oe <= 1'b1;
                st     <= S_DACK;
              end else st <= S_IDLE;
            end else if (st == S_REG) begin
              ptr    <= shr[3:0];
              sda_oe <= 1'b1;
              st     <= S_AACK;
            end else begin
              if (ptr == 4'hF) ctl_q <= shr & CTL_MASK;
              if (ptr == 4'hE) dis_q <= shr & DIS_MASK;
              ptr    <= ptr_nxt;
              sda_oe <= 1'b1;
              st     <= S_WACK;
            end
          end
        end
        S_DACK: begin
          if (scl_fall) begin
            if (rw) begin
              shr    <= rd_ptr;
              ptr    <= ptr_nxt;
              sda_oe <= ~rd_ptr[7];
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_REG;
            end
          end
        end
        S_AACK, S_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_WDATA;
          end
        end
        S_RD: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              shr    <= {shr[6:0], 1'b0};
              sda_oe <= ~shr[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_f;
          else if (scl_fall) begin
            if (mack) begin
              shr    <= rd_ptr;
              ptr    <= ptr_nxt;
              sda_oe <= ~rd_ptr[7];
              st     <= S_RD;
            end else st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign pwr_down  = ctl_q[7];
  assign clk34_sel = ctl_q[3:2];
  assign clk2_alt  = ctl_q[1];
  assign clk1_alt  = ctl_q[0];
  assign out_off   = dis_q[7:3];

endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       scl_f,
  input logic       sda_f,
  input logic       start,
  input logic [3:0] st,
  input logic       sda_oe,
  input logic [9:0] outs
);
  localparam logic [3:0] C_DEV = 4'd1, C_WDATA = 4'd5, C_MACK = 4'd8;

  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  assert_scl_filtered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> (scl_f == $past(scl_s)) && (scl_f == $past(scl_s, 2)));

  assert_sda_filtered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_f) |-> (sda_f == $past(sda_s)) && (sda_f == $past(sda_s, 2)));

  assert_outs_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outs) |-> $past(st) == C_WDATA);

  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> st == C_DEV);

  assert_mack_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_MACK |-> !sda_oe);
endmodule

bind twi_regslave twi_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(s2[0]), .sda_s(s2[1]), .scl_f(filt[0]), .sda_f(filt[1]),
  .start(start), .st(st), .sda_oe(sda_oe),
  .outs({pwr_down, clk34_sel, clk2_alt, clk1_alt, out_off})
);

// File: tb/tb_twi_regslave.sv
module tb_twi_regslave;
  localparam int Q = 12;
  localparam logic [6:0] DEV = 7'b1010110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, pwr_down, clk2_alt, clk1_alt;
  logic [1:0] clk34_sel;
  logic [4:0] out_off;
  logic sda_bus;
  int n_chk = 0, n_fail = 0, viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_ff = 8'h0C, exp_fe = 8'h00;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twi_regslave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pwr_down(pwr_down), .clk34_sel(clk34_sel), .clk2_alt(clk2_alt),
    .clk1_alt(clk1_alt), .out_off(out_off)
  );

  always @(posedge clk) begin
    if (rst_n && scl_m && sda_oe !== prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart;
    sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b1; tk(2 * Q);
  endtask

  task automatic wbit(logic b, int g);
    sda_m = b;
    if (g == 1) begin
      tk(2); scl_m = 1'b1; tk(5); scl_m = 1'b0; tk(Q - 7);
    end else tk(Q);
    scl_m = 1'b1;
    if (g == 2) begin
      tk(4); sda_m = 1'b0; tk(5); sda_m = b; tk(2 * Q - 9);
    end else tk(2 * Q);
    scl_m = 1'b0; tk(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q); b = sda_bus; tk(Q); scl_m = 1'b0; tk(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack, input int gpos = -1, input int gmode = 0);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i], (i == gpos) ? gmode : 0);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~mack, 0);
  endtask

  task automatic wr1(logic [7:0] ra, logic [7:0] d, string tag);
    logic a0, a1, a2;
    bstart; wbyte({DEV, 1'b0}, a0); wbyte(ra, a1); wbyte(d, a2); bstop;
    check({tag, " write acks"}, {a0, a1, a2}, 3'b111);
  endtask

  task automatic rd_rand(logic [7:0] ra, output logic [7:0] d);
    logic a0, a1, a2;
    bstart; wbyte({DEV, 1'b0}, a0); wbyte(ra, a1);
    bstart; wbyte({DEV, 1'b1}, a2); rbyte(d, 1'b0); bstop;
    check("R6 random read acks", {a0, a1, a2}, 3'b111);
  endtask

  task automatic rd_cur(output logic [7:0] d);
    logic a0;
    bstart; wbyte({DEV, 1'b1}, a0); rbyte(d, 1'b0); bstop;
    check("R5 current read ack", a0, 1'b1);
  endtask

  task automatic chk_outs(string tag);
    check({tag, " R11 pwr_down"}, pwr_down, exp_ff[7]);
    check({tag, " R11 clk34_sel"}, clk34_sel, exp_ff[3:2]);
    check({tag, " R11 clk2_alt"}, clk2_alt, exp_ff[1]);
    check({tag, " R11 clk1_alt"}, clk1_alt, exp_ff[0]);
    check({tag, " R11 out_off"}, out_off, exp_fe[7:3]);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a, a0, a1;
    tk(5); rst_n = 1'b1; tk(5);

    // R1: reset values
    check("R1 sda released", sda_oe, 1'b0);
    chk_outs("R1");
    rd_cur(d); check("R1 R5 first current read is 0xFE", d, 8'h00);
    rd_cur(d); check("R1 R5 second current read is 0xFF", d, 8'h0C);

    // R2: device address sweep
    for (int k = 0; k < 128; k++) begin
      bstart; wbyte({k[6:0], 1'b0}, a); bstop;
      check($sformatf("R2 ack for address %0h", k), a, (k[6:0] == DEV));
    end
    bstart; wbyte({7'h2B, 1'b1}, a); bstop;
    check("R2 foreign read address unacked", a, 1'b0);

    // R3 / R11: byte write patterns with readback
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = 8'(i * 8'h25 + 8'h13);
      wr1(8'hFF, v, "R3"); exp_ff = v & 8'h8F;
      wr1(8'hFE, ~v, "R3"); exp_fe = ~v & 8'hF8;
      chk_outs("R3");
      rd_rand(8'hFF, d); check("R3 R6 readback 0xFF", d, exp_ff);
      rd_rand(8'hFE, d); check("R3 R6 readback 0xFE", d, exp_fe);
    end

    // R4: multi-byte write across the wrap
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'hFE, a);
    wbyte(8'hFF, a); wbyte(8'hFF, a); wbyte(8'h28, a0); bstop;
    check("R4 last page byte ack", a0, 1'b1);
    exp_fe = 8'h28; exp_ff = 8'h8F;
    chk_outs("R4");
    rd_cur(d); check("R4 R5 current read after page write", d, 8'h8F);
    rd_cur(d); check("R5 wrap 0xFF to 0xFE", d, 8'h28);

    // R7 / R8: sequential read from an unimplemented address
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'hFD, a0);
    bstart; wbyte({DEV, 1'b1}, a1);
    check("R8 unimplemented address acked", a0, 1'b1);
    rbyte(d, 1'b1); check("R8 read 0xFD is zero", d, 8'h00);
    rbyte(d, 1'b1); check("R7 seq 0xFE", d, 8'h28);
    rbyte(d, 1'b1); check("R7 seq 0xFF", d, 8'h8F);
    rbyte(d, 1'b1); check("R7 seq wrap 0xFE", d, 8'h28);
    rbyte(d, 1'b0); check("R7 seq 0xFF", d, 8'h8F);
    tk(Q); check("R7 released after NACK", sda_oe, 1'b0);
    bstop;

    // R8: ignored write, upper nibble ignored
    wr1(8'hF5, 8'h3C, "R8");
    chk_outs("R8 ignored write");
    rd_rand(8'h37, d); check("R8 read 0x37 is zero", d, 8'h00);
    wr1(8'h0F, 8'h01, "R8"); exp_ff = 8'h01;
    chk_outs("R8 0x0F aliases 0xFF");

    // R9: STOP in mid byte
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'hFF, a);
    for (int i = 0; i < 4; i++) wbit(1'b1, 0);
    bstop;
    chk_outs("R9 stop abort");
    // R9: START in mid byte
    bstart; wbyte({DEV, 1'b0}, a); wbyte(8'hFF, a);
    for (int i = 0; i < 5; i++) wbit(1'b1, 0);
    bstart; wbyte({DEV, 1'b0}, a0); wbyte(8'hFE, a); wbyte(8'hC0, a); bstop;
    check("R9 restart acked", a0, 1'b1);
    exp_fe = 8'hC0;
    chk_outs("R9 start abort");

    // R10: glitches on both lines
    bstart;
    wbyte({DEV, 1'b0}, a0, 3, 1);
    wbyte(8'hFF, a1, 6, 2);
    wbyte(8'h85, a, 7, 2);
    bstop;
    check("R10 acks under glitches", {a0, a1, a}, 3'b111);
    exp_ff = 8'h85;
    chk_outs("R10");

    check("R12 drive changed only while clock low", viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule